// File: doc/BRIEF.md
# Sequential Binary-to-Decimal Digit Writer

This block turns an unsigned binary value into its decimal digits, most significant first, and stores each digit as one byte through a simple write port. A request carries the value and a base address. The hundreds digit goes to the base address, the tens digit to the next byte and the ones digit to the byte after that. The address wraps around the top of the address space.

The conversion has no divider and no shift-add network. For each decimal weight in turn (100, then 10, then 1) the block first stores a zero digit. It then subtracts the weight from a running remainder once per clock. Every subtraction that does not borrow commits the new remainder and writes the incremented digit back to the same byte. The first subtraction that would borrow leaves the remainder as it is, and the block moves on to the next weight. The source value and the base address are kept in registers. Both are shown unchanged on the outputs when the block reports completion, so a caller can reuse them.

Top module: `bcd_sub_conv`

## Requirements
- R1: While reset is held and in the first cycle after it, `busy`, `done` and `wr_en` are all 0.
- R2: A `start` is accepted only when `busy` is 0. A `start` raised while `busy` is 1 has no effect on the bytes written, the outputs or the timing. With no `start`, no write takes place.
- R3: The writes for one conversion go to digit positions in the order hundreds, tens, ones. Each position's first write carries the value 0.
- R4: After its zero write, a position receives one write per non-borrowing subtraction, carrying 1, 2, … up to the final digit. One conversion therefore makes exactly 3 + (sum of the three digits) writes.
- R5: When a subtraction would borrow, the remainder is kept for the next weight. The last bytes written at offsets 0, 1 and 2 equal v/100, (v/10) mod 10 and v mod 10, each zero-extended into the byte.
- R6: Every write address equals the base plus an offset of 0, 1 or 2, computed modulo 2^ADDR_W.
- R7: `done` is high for exactly one cycle. It rises 10 + (sum of the digits) clock edges after the edge that accepts `start`, counting that edge as the first.
- R8: When `done` is high, `out_value` equals the accepted value and `out_base` equals the accepted base. Both stay stable throughout the conversion.
- R9: `wr_en` is never 1 while `busy` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Request a conversion; taken only when idle |
| value_in | input | VAL_W | Binary value to convert |
| base_in | input | ADDR_W | Byte address for the hundreds digit |
| busy | output | 1 | A conversion is in progress (includes the done cycle) |
| done | output | 1 | One-cycle completion pulse |
| out_value | output | VAL_W | Accepted source value, returned unchanged |
| out_base | output | ADDR_W | Accepted base address, returned unchanged |
| wr_en | output | 1 | Byte write strobe |
| wr_addr | output | ADDR_W | Byte write address |
| wr_data | output | BYTE_W | Byte write data (one decimal digit) |

## Verification
All 256 input values are converted. The bench replays the exact write sequence it expects (zero, then each count, position by position), so a design that skipped the zero write, wrote digits out of order or reached 10 in a column would break the sequence. Values whose digits are zero or nine, such as 0, 9, 10, 99, 100 and 199, catch a design that subtracted once too often or too seldom at a borrow boundary, because the final digits and the exact latency would differ. Bases at the top of the address space catch an address adder that fails to wrap. A `start` injected in mid-conversion with a different value and base catches a design that reloads while busy, because its digits and its returned value would change.

// File: rtl/bcd_sub_pkg.sv
package bcd_sub_pkg;

  typedef enum logic [2:0] {
    ST_IDLE  = 3'd0,
    ST_CLEAR = 3'd1,
    ST_SUB   = 3'd2,
    ST_NEXT  = 3'd3,
    ST_DONE  = 3'd4
  } conv_state_t;

  // Decimal weight 10^n
  function automatic int unsigned pow10(input int unsigned n);
    int unsigned acc;
    acc = 1;
    for (int unsigned k = 0; k < n; k++) acc = acc * 10;
    return acc;
  endfunction

  // Trial subtraction: bit 32 is the borrow, bits 31:0 the difference
  function automatic logic [32:0] trial_sub(input logic [31:0] minuend,
                                            input logic [31:0] weight);
    return {1'b0, minuend} - {1'b0, weight};
  endfunction

endpackage

// File: rtl/bcd_sub_ctrl.sv
module bcd_sub_ctrl
  import bcd_sub_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        start,
  input  logic        borrow,
  input  logic        last_idx,
  output conv_state_t state_q,
  output logic        ev_accept,
  output logic        ev_clear,
  output logic        ev_take,
  output logic        ev_step,
  output logic        busy,
  output logic        done
);

  conv_state_t state_d;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_IDLE:  if (start) state_d = ST_CLEAR;
      ST_CLEAR: state_d = ST_SUB;
      ST_SUB:   if (borrow) state_d = ST_NEXT;
      ST_NEXT:  state_d = last_idx ? ST_DONE : ST_CLEAR;
      ST_DONE:  state_d = ST_IDLE;
      default:  state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) state_q <= ST_IDLE;
    else        state_q <= state_d;
  end

  assign ev_accept = (state_q == ST_IDLE) && start;
  assign ev_clear  = (state_q == ST_CLEAR);
  assign ev_take   = (state_q == ST_SUB) && !borrow;
  assign ev_step   = (state_q == ST_NEXT) && !last_idx;
  assign busy      = (state_q != ST_IDLE);
  assign done      = (state_q == ST_DONE);

endmodule

// File: rtl/bcd_sub_datapath.sv
module bcd_sub_datapath
  import bcd_sub_pkg::*;
#(
  parameter int VAL_W = 8,
  parameter int NDIG  = 3,
  parameter int DIG_W = 4,
  parameter int IDX_W = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [VAL_W-1:0] value_in,
  input  logic             ev_accept,
  input  logic             ev_clear,
  input  logic             ev_take,
  input  logic             ev_step,
  output logic             borrow,
  output logic             last_idx,
  output logic [IDX_W-1:0] idx_q,
  output logic [DIG_W-1:0] digit_inc,
  output logic [VAL_W-1:0] rem_q,
  output logic [VAL_W-1:0] src_q
);

  logic [VAL_W-1:0] weight_tab [NDIG];
  logic [VAL_W-1:0] weight_sel;
  logic [32:0]      trial;
  logic [DIG_W-1:0] digit_q;

  // Weight table, most significant position first
  for (genvar g = 0; g < NDIG; g++) begin : g_weight
    assign weight_tab[g] = VAL_W'(pow10(NDIG - 1 - g));
  end

  always_comb begin
    weight_sel = '0;
    for (int k = 0; k < NDIG; k++)
      if (idx_q == IDX_W'(k)) weight_sel = weight_tab[k];
  end

  assign trial     = trial_sub(32'(rem_q), 32'(weight_sel));
  assign borrow    = trial[32];
  assign last_idx  = (idx_q == IDX_W'(NDIG - 1));
  assign digit_inc = digit_q + DIG_W'(1);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rem_q   <= '0;
      src_q   <= '0;
      idx_q   <= '0;
      digit_q <= '0;
    end else begin
      if (ev_accept) begin
        rem_q   <= value_in;
        src_q   <= value_in;
        idx_q   <= '0;
        digit_q <= '0;
      end
      if (ev_clear) digit_q <= '0;
      if (ev_take) begin
        rem_q   <= trial[VAL_W-1:0];
        digit_q <= digit_inc;
      end
      if (ev_step) idx_q <= idx_q + IDX_W'(1);
    end
  end

endmodule

// File: rtl/bcd_sub_wrport.sv
module bcd_sub_wrport #(
  parameter int ADDR_W = 12,
  parameter int BYTE_W = 8,
  parameter int DIG_W  = 4,
  parameter int IDX_W  = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] base_in,
  input  logic              ev_accept,
  input  logic              ev_clear,
  input  logic              ev_take,
  input  logic [IDX_W-1:0]  idx_q,
  input  logic [DIG_W-1:0]  digit_inc,
  output logic [ADDR_W-1:0] base_q,
  output logic              wr_en,
  output logic [ADDR_W-1:0] wr_addr,
  output logic [BYTE_W-1:0] wr_data
);

  always_ff @(posedge clk) begin
    if (!rst_n)         base_q <= '0;
    else if (ev_accept) base_q <= base_in;
  end

  assign wr_en   = ev_clear || ev_take;
  assign wr_addr = base_q + ADDR_W'(idx_q);
  assign wr_data = ev_take ? BYTE_W'(digit_inc) : '0;

endmodule

// File: rtl/bcd_sub_conv.sv
module bcd_sub_conv
  import bcd_sub_pkg::*;
#(
  parameter int VAL_W  = 8,
  parameter int ADDR_W = 12,
  parameter int BYTE_W = 8,
  parameter int NDIG   = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [VAL_W-1:0]  value_in,
  input  logic [ADDR_W-1:0] base_in,
  output logic              busy,
  output logic              done,
  output logic [VAL_W-1:0]  out_value,
  output logic [ADDR_W-1:0] out_base,
  output logic              wr_en,
  output logic [ADDR_W-1:0] wr_addr,
  output logic [BYTE_W-1:0] wr_data
);

  localparam int DIG_W = 4;
  localparam int IDX_W = (NDIG > 1) ? $clog2(NDIG) : 1;

  conv_state_t      state_q;
  logic             ev_accept, ev_clear, ev_take, ev_step;
  logic             borrow, last_idx;
  logic [IDX_W-1:0] idx_q;
  logic [DIG_W-1:0] digit_inc;
  logic [VAL_W-1:0] rem_q;

  bcd_sub_ctrl u_ctrl (
    .clk       (clk),
    .rst_n     (rst_n),
    .start     (start),
    .borrow    (borrow),
    .last_idx  (last_idx),
    .state_q   (state_q),
    .ev_accept (ev_accept),
    .ev_clear  (ev_clear),
    .ev_take   (ev_take),
    .ev_step   (ev_step),
    .busy      (busy),
    .done      (done)
  );

  bcd_sub_datapath #(
    .VAL_W (VAL_W),
    .NDIG  (NDIG),
    .DIG_W (DIG_W),
    .IDX_W (IDX_W)
  ) u_dp (
    .clk       (clk),
    .rst_n     (rst_n),
    .value_in  (value_in),
    .ev_accept (ev_accept),
    .ev_clear  (ev_clear),
    .ev_take   (ev_take),
    .ev_step   (ev_step),
    .borrow    (borrow),
    .last_idx  (last_idx),
    .idx_q     (idx_q),
    .digit_inc (digit_inc),
    .rem_q     (rem_q),
    .src_q     (out_value)
  );

  bcd_sub_wrport #(
    .ADDR_W (ADDR_W),
    .BYTE_W (BYTE_W),
    .DIG_W  (DIG_W),
    .IDX_W  (IDX_W)
  ) u_wr (
    .clk       (clk),
    .rst_n     (rst_n),
    .base_in   (base_in),
    .ev_accept (ev_accept),
    .ev_clear  (ev_clear),
    .ev_take   (ev_take),
    .idx_q     (idx_q),
    .digit_inc (digit_inc),
    .base_q    (out_base),
    .wr_en     (wr_en),
    .wr_addr   (wr_addr),
    .wr_data   (wr_data)
  );

endmodule

// File: rtl/bcd_sub_conv_chk.sv
module bcd_sub_conv_chk #(
  parameter int VAL_W  = 8,
  parameter int ADDR_W = 12,
  parameter int BYTE_W = 8,
  parameter int NDIG   = 3
) (
  input logic              clk,
  input logic              rst_n,
  input logic              busy,
  input logic              done,
  input logic              wr_en,
  input logic [ADDR_W-1:0] wr_addr,
  input logic [BYTE_W-1:0] wr_data,
  input logic [ADDR_W-1:0] out_base,
  input logic [VAL_W-1:0]  out_value,
  input logic [VAL_W-1:0]  rem_q,
  input logic              ev_clear,
  input logic              ev_take
);

  a_r9_write_needs_busy: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |-> busy);

  a_r3_clear_writes_zero: assert property (@(posedge clk) disable iff (!rst_n)
    ev_clear |-> (wr_en && wr_data == '0));

  a_r4_take_writes_count: assert property (@(posedge clk) disable iff (!rst_n)
    ev_take |-> (wr_en && wr_data != '0 && wr_data < BYTE_W'(10)));

  a_r6_addr_window: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |-> (ADDR_W'(wr_addr - out_base) < ADDR_W'(NDIG)));

  a_r7_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  a_r8_value_held: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && $past(busy)) |-> ($stable(out_value) && $stable(out_base)));

  a_r5_rem_shrinks: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && $past(busy)) |-> (rem_q <= $past(rem_q)));

endmodule

bind bcd_sub_conv bcd_sub_conv_chk #(
  .VAL_W (VAL_W),
  .ADDR_W(ADDR_W),
  .BYTE_W(BYTE_W),
  .NDIG  (NDIG)
) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .busy      (busy),
  .done      (done),
  .wr_en     (wr_en),
  .wr_addr   (wr_addr),
  .wr_data   (wr_data),
  .out_base  (out_base),
  .out_value (out_value),
  .rem_q     (rem_q),
  .ev_clear  (ev_clear),
  .ev_take   (ev_take)
);

// File: tb/bcd_sub_conv_tb.sv
module bcd_sub_conv_tb;

  localparam int CLK_PERIOD = 10;
  localparam int VAL_W  = 8;
  localparam int ADDR_W = 12;
  localparam int BYTE_W = 8;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic              start = 1'b0;
  logic [VAL_W-1:0]  value_in = '0;
  logic [ADDR_W-1:0] base_in = '0;
  logic              busy, done, wr_en;
  logic [VAL_W-1:0]  out_value;
  logic [ADDR_W-1:0] out_base, wr_addr;
  logic [BYTE_W-1:0] wr_data;

  int errs = 0;
  int checks = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  bcd_sub_conv #(.VAL_W(VAL_W), .ADDR_W(ADDR_W), .BYTE_W(BYTE_W), .NDIG(3)) u_dut (
    .clk(clk), .rst_n(rst_n), .start(start), .value_in(value_in), .base_in(base_in),
    .busy(busy), .done(done), .out_value(out_value), .out_base(out_base),
    .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data)
  );

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    checks++;
    if (!ok) begin
      errs++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic run_conv(input int v, input int b, input bit poke);
    int dig[3];
    int lastv[3];
    int pos, cnt, seq_bad, outside, nwr, cyc, sum;
    bit got_done;
    dig[0] = v / 100; dig[1] = (v / 10) % 10; dig[2] = v % 10;
    sum = dig[0] + dig[1] + dig[2];
    lastv[0] = -1; lastv[1] = -1; lastv[2] = -1;
    pos = 0; cnt = 0; seq_bad = 0; outside = 0; nwr = 0; cyc = 0; got_done = 0;
    @(negedge clk);
    value_in = VAL_W'(v);
    base_in  = ADDR_W'(b);
    start    = 1'b1;
    while (!got_done && cyc < 100) begin
      @(posedge clk);
      cyc++;
      @(negedge clk);
      if (cyc == 1) start = 1'b0;
      if (poke && cyc == 5) begin
        start = 1'b1; value_in = VAL_W'(~v); base_in = ADDR_W'(b ^ 5);
      end
      if (poke && cyc == 6) start = 1'b0;
      if (wr_en) begin
        int off;
        nwr++;
        off = int'(ADDR_W'(wr_addr - ADDR_W'(b)));
        if (off > 2) outside++;
        else begin
          lastv[off] = int'(wr_data);
          if (pos > 2 || off != pos || int'(wr_data) != cnt) seq_bad++;
          else begin
            cnt++;
            if (cnt > dig[pos]) begin pos++; cnt = 0; end
          end
        end
      end
      if (done) got_done = 1'b1;
    end
    chk(got_done, "R7", "done seen", int'(got_done), 1);
    chk(cyc == 10 + sum, "R7", "latency", cyc, 10 + sum);
    chk(seq_bad == 0 && pos == 3, "R3", "write order/zero-first", seq_bad, 0);
    chk(nwr == 3 + sum, "R4", "write count", nwr, 3 + sum);
    chk(outside == 0, "R6", "writes outside window", outside, 0);
    for (int p = 0; p < 3; p++)
      chk(lastv[p] == dig[p], "R5", "final digit", lastv[p], dig[p]);
    chk(int'(out_value) == v, "R8", "returned value", int'(out_value), v);
    chk(int'(out_base) == b, "R8", "returned base", int'(out_base), b);
    if (poke) chk(1'b1, "R2", "start ignored while busy (digits above)", 0, 0);
    @(posedge clk);
    @(negedge clk);
    chk(!done, "R7", "done one cycle", int'(done), 0);
    chk(!wr_en && !busy, "R9", "quiet after done", int'(wr_en), 0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errs++;
    checks++;
    $display("FAIL watchdog expired: actual=1 expected=0");
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    chk(!busy && !done && !wr_en, "R1", "outputs in reset", int'(busy|done|wr_en), 0);
    rst_n = 1'b1;
    @(posedge clk);
    @(negedge clk);
    chk(!busy && !done && !wr_en, "R1", "outputs after reset", int'(busy|done|wr_en), 0);
    begin
      int idle_wr;
      idle_wr = 0;
      for (int k = 0; k < 6; k++) begin
        @(posedge clk);
        @(negedge clk);
        if (wr_en || busy) idle_wr++;
      end
      chk(idle_wr == 0, "R2", "no activity without start", idle_wr, 0);
    end
    for (int v = 0; v < 256; v++)
      run_conv(v, (v * 37) % 4096, (v % 16) == 3);
    run_conv(255, 12'hFFE, 1'b0);
    run_conv(199, 12'hFFF, 1'b1);
    run_conv(100, 12'hFFD, 1'b0);
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end

endmodule